// File: doc/BRIEF.md
# Digit-Serial Constant Multiplier for 29x and 43x

This block multiplies one two's-complement input stream by the two fixed constants 29 and 43 at once, using digit-serial shift-add arithmetic. The input word enters `DW` bits per clock, least significant digit first, and a start strobe marks its first digit. Both products leave in the same digit-serial format. A matching strobe marks their first digits, and the latency is fixed.

Both products come from one shared partial product, 7x = 8x - x. From it, 29x = 4·7x + x and 43x = 29x + 2·7x. Only three digit-serial operations are used, where plain binary recoding of the two constants would need six. In digit-serial form a left shift is a delay: every shift is built from flip-flops that hold earlier digits, and zeros are fed into the low bits at the start of each word.

A word frame is `ceil((NW+6)/DW)` digits long, which is enough for the full 43x result. The first `NW/DW` digits carry the input. During the remaining digits the block replaces the input with copies of the input's sign bit. Each adder keeps its carry in a flip-flop between digits, and the subtractor inverts its second operand and starts each word with a carry of one. The parameter `DW` must be 1, 2 or 4, and `NW` must be a multiple of `DW`.

Top module: `ds_mcm_29_43`

## Requirements
- R1: Over the `ceil((NW+6)/DW)` digits that follow the output strobe, `p29_digit` carries 29·x as a two's-complement number of that many digits, least significant digit first.
- R2: Over the same digits, `p43_digit` carries 43·x in the same format.
- R3: `out_stb` equals `in_stb` delayed by exactly 3 clock cycles. Output digit j of a word appears 3 cycles after input digit j of that word.
- R4: The input digits at frame positions `NW/DW` and later have no effect on the results. The block uses sign-extension digits in their place, each filled with bit `DW-1` of input digit `NW/DW-1`.
- R5: Words sent back to back, one strobe every frame length, give results that do not depend on the previous word. Carries and shift history restart at each strobe.
- R6: A strobe that arrives before the current word has finished abandons that word and starts a new one. The new word's results are exact.
- R7: The most negative and the most positive `NW`-bit inputs give exact results for both constants.
- R8: While reset is asserted and right after it, `out_stb` is 0 and both product digits are 0.
- R9: Idle cycles of any length between words do not change the results of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_stb | input | 1 | High with the least significant digit of a new input word |
| in_digit | input | DW | Current input digit, two's complement word, least significant digit first |
| out_stb | output | 1 | High with the least significant digit of the products |
| p29_digit | output | DW | Current digit of 29·x |
| p43_digit | output | DW | Current digit of 43·x |

## Verification
Some properties are checked on every cycle. The output strobe must lag the input strobe by three cycles. The first digits of both products must equal the low `DW` bits of 29 and 43 times the first input digit. Every sign-extension digit fed to the datapath must be all zeros or all ones, and the outputs must never be unknown. Full-word correctness needs the bench's scenarios: borrows and carries that ripple across digits, bit shifts that cross digit boundaries, tail input digits that are ignored, aborted words, and idle gaps. The bench compares every output digit against a behavioural model.

// File: rtl/ds_mcm_pkg.sv
package ds_mcm_pkg;

   // integer ceiling division used to size frames
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // number of extra result bits needed beyond the input width for 43x
   localparam int GROWTH_BITS = 6;

endpackage

// File: rtl/ds_shift.sv
// Digit-serial left shift by SH bit positions: a delay made of flip-flops.
// History is treated as zero on the start digit so zeros enter the low bits.
module ds_shift #(
   parameter int DW = 2,
   parameter int SH = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   localparam int HD = (SH + DW - 1) / DW;   // digits of history kept

   if (SH < 0) begin : g_bad_shift
      $error("ds_shift: SH must not be negative");
   end

   if (HD == 0) begin : g_pass
      assign dout = din;
   end else begin : g_delay
      logic [HD*DW-1:0]     hist_q;
      logic [HD*DW-1:0]     hist_eff;
      logic [(HD+1)*DW-1:0] window;

      assign hist_eff = start ? '0 : hist_q;
      assign window   = {din, hist_eff};
      assign dout     = window[HD*DW-SH +: DW];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_q <= '0;
         end else begin
            hist_q <= window[(HD+1)*DW-1:DW];
         end
      end
   end

endmodule

// File: rtl/ds_addsub.sv
// Digit-serial adder or subtractor with a registered result digit.
// The carry flip-flop restarts on the start digit (0 for add, 1 for subtract).
module ds_addsub #(
   parameter int DW  = 2,
   parameter bit SUB = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] sum_q
);
   logic          carry_q;
   logic          cin;
   logic [DW-1:0] b_eff;
   logic [DW:0]   total;

   if (SUB) begin : g_sub
      assign b_eff = ~b;
      assign cin   = start ? 1'b1 : carry_q;
   end else begin : g_add
      assign b_eff = b;
      assign cin   = start ? 1'b0 : carry_q;
   end

   assign total = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q   <= '0;
         carry_q <= 1'b0;
      end else begin
         sum_q   <= total[DW-1:0];
         carry_q <= total[DW];
      end
   end

endmodule

// File: rtl/ds_delay.sv
// Plain digit delay line used to balance operand paths.
module ds_delay #(
   parameter int DW     = 2,
   parameter int STAGES = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   if (STAGES < 1) begin : g_bad_stages
      $error("ds_delay: STAGES must be at least 1");
   end

   logic [DW-1:0] pipe_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe_q[s] <= '0;
         end else if (s == 0) begin
            pipe_q[s] <= din;
         end else begin
            pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/ds_framer.sv
// Word framing: tracks the digit index and replaces tail digits with sign copies.
module ds_framer #(
   parameter int DW = 2,
   parameter int NW = 8,
   parameter int ND_OUT = 7,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] x_ext,
   output logic [CW-1:0] idx
);
   localparam int ND_IN = NW / DW;

   logic [CW-1:0] cnt_q;
   logic          sign_q;

   assign idx   = stb ? '0 : cnt_q;
   assign x_ext = (idx < CW'(ND_IN)) ? din : {DW{sign_q}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CW'(ND_OUT);
         sign_q <= 1'b0;
      end else begin
         if (idx < CW'(ND_OUT)) begin
            cnt_q <= idx + CW'(1);
         end
         if (idx == CW'(ND_IN - 1)) begin
            sign_q <= din[DW-1];
         end
      end
   end

endmodule

// File: rtl/ds_mcm_29_43.sv
// Digit-serial multiplier of one stream by 29 and 43 via a shared 7x term.
module ds_mcm_29_43
   import ds_mcm_pkg::*;
#(
   parameter int DW = 2,
   parameter int NW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_stb,
   input  logic [DW-1:0] in_digit,
   output logic          out_stb,
   output logic [DW-1:0] p29_digit,
   output logic [DW-1:0] p43_digit
);
   localparam int FRAME_BITS = NW + GROWTH_BITS;
   localparam int ND_OUT     = ceil_div(FRAME_BITS, DW);
   localparam int CW         = $clog2(ND_OUT + 1);
   localparam int LATENCY    = 3;

   if (!(DW == 1 || DW == 2 || DW == 4)) begin : g_bad_dw
      $error("ds_mcm_29_43: DW must be 1, 2 or 4");
   end
   if (NW < DW || (NW % DW) != 0) begin : g_bad_nw
      $error("ds_mcm_29_43: NW must be a positive multiple of DW");
   end

   // strobe alignment for each pipeline stage
   logic [LATENCY:1] stb_q;
   logic [LATENCY:0] stb_at;
   assign stb_at = {stb_q, in_stb};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q <= '0;
      end else begin
         stb_q <= stb_at[LATENCY-1:0];
      end
   end

   // stage 0: framing and sign extension
   logic [DW-1:0] x_ext;
   logic [CW-1:0] dig_idx;

   ds_framer #(.DW(DW), .NW(NW), .ND_OUT(ND_OUT), .CW(CW)) i_framer (
      .clk(clk), .rst_n(rst_n), .stb(in_stb), .din(in_digit),
      .x_ext(x_ext), .idx(dig_idx)
   );

   // stage 1: 7x = 8x - x
   logic [DW-1:0] x_sh3;
   logic [DW-1:0] m7;
   logic [DW-1:0] x_d1;

   ds_shift #(.DW(DW), .SH(3)) i_sh_x8 (
      .clk(clk), .rst_n(rst_n), .start(stb_at[0]), .din(x_ext), .dout(x_sh3)
   );
   ds_addsub #(.DW(DW), .SUB(1'b1)) i_sub_m7 (
      .clk(clk), .rst_n(rst_n), .start(stb_at[0]), .a(x_sh3), .b(x_ext), .sum_q(m7)
   );
   ds_delay #(.DW(DW), .STAGES(1)) i_dly_x (
      .clk(clk), .rst_n(rst_n), .din(x_ext), .dout(x_d1)
   );

   // stage 2: 29x = 4*7x + x, with 2*7x balanced alongside
   logic [DW-1:0] m28;
   logic [DW-1:0] m14;
   logic [DW-1:0] m14_d;
   logic [DW-1:0] m29;

   ds_shift #(.DW(DW), .SH(2)) i_sh_m28 (
      .clk(clk), .rst_n(rst_n), .start(stb_at[1]), .din(m7), .dout(m28)
   );
   ds_shift #(.DW(DW), .SH(1)) i_sh_m14 (
      .clk(clk), .rst_n(rst_n), .start(stb_at[1]), .din(m7), .dout(m14)
   );
   ds_addsub #(.DW(DW), .SUB(1'b0)) i_add_m29 (
      .clk(clk), .rst_n(rst_n), .start(stb_at[1]), .a(m28), .b(x_d1), .sum_q(m29)
   );
   ds_delay #(.DW(DW), .STAGES(1)) i_dly_m14 (
      .clk(clk), .rst_n(rst_n), .din(m14), .dout(m14_d)
   );

   // stage 3: 43x = 29x + 2*7x, 29x balanced to the same cycle
   logic [DW-1:0] m43;
   logic [DW-1:0] m29_d;

   ds_addsub #(.DW(DW), .SUB(1'b0)) i_add_m43 (
      .clk(clk), .rst_n(rst_n), .start(stb_at[2]), .a(m29), .b(m14_d), .sum_q(m43)
   );
   ds_delay #(.DW(DW), .STAGES(1)) i_dly_m29 (
      .clk(clk), .rst_n(rst_n), .din(m29), .dout(m29_d)
   );

   assign out_stb   = stb_at[LATENCY];
   assign p29_digit = m29_d;
   assign p43_digit = m43;

endmodule

// File: rtl/ds_mcm_29_43_chk.sv
// Property checker attached to the top module.
module ds_mcm_29_43_chk #(
   parameter int DW = 2,
   parameter int NW = 8,
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_stb,
   input logic [DW-1:0] in_digit,
   input logic          out_stb,
   input logic [DW-1:0] p29_digit,
   input logic [DW-1:0] p43_digit,
   input logic [DW-1:0] x_ext,
   input logic [CW-1:0] dig_idx
);
   localparam int ND_IN = NW / DW;

   logic [1:0]    cyc_q;
   logic [DW-1:0] d_hist [3];
   logic [2:0]    s_hist;
   logic [DW+5:0] lsd29;
   logic [DW+5:0] lsd43;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         s_hist <= '0;
         for (int i = 0; i < 3; i++) d_hist[i] <= '0;
      end else begin
         if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
         s_hist    <= {s_hist[1:0], in_stb};
         d_hist[0] <= in_digit;
         d_hist[1] <= d_hist[0];
         d_hist[2] <= d_hist[1];
      end
   end

   assign lsd29 = {6'd0, d_hist[2]} * (DW+6)'(29);
   assign lsd43 = {6'd0, d_hist[2]} * (DW+6)'(43);

   AST_STB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd3) |-> (out_stb == s_hist[2])); // R3

   AST_LSD_29: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd3 && out_stb) |-> (p29_digit == lsd29[DW-1:0])); // R1

   AST_LSD_43: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd3 && out_stb) |-> (p43_digit == lsd43[DW-1:0])); // R2

   AST_TAIL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_idx >= CW'(ND_IN)) |-> (x_ext == '0 || x_ext == '1)); // R4

   AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({out_stb, p29_digit, p43_digit})); // R8

endmodule

bind ds_mcm_29_43 ds_mcm_29_43_chk #(.DW(DW), .NW(NW), .CW(CW)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_digit(in_digit),
   .out_stb(out_stb), .p29_digit(p29_digit), .p43_digit(p43_digit),
   .x_ext(x_ext), .dig_idx(dig_idx)
);

// File: tb/test_ds_mcm_29_43.sv
`timescale 1ns/1ps
module test_ds_mcm_29_43;
   localparam int DW     = 2;
   localparam int NW     = 8;
   localparam int ND_IN  = NW / DW;
   localparam int ND_OUT = (NW + 6 + DW - 1) / DW;
   localparam int LAT    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_stb = 1'b0;
   logic [DW-1:0] in_digit = '0;
   logic          out_stb;
   logic [DW-1:0] p29_digit;
   logic [DW-1:0] p43_digit;

   int  errors = 0;
   int  checks = 0;
   bit  done = 1'b0;

   typedef struct {
      bit            chk;
      bit            stb;
      logic [DW-1:0] e29;
      logic [DW-1:0] e43;
      string         tag;
   } exp_t;

   exp_t exp_q[$];

   always #2 clk = ~clk;

   ds_mcm_29_43 #(.DW(DW), .NW(NW)) i_ds_mcm_29_43 (
      .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_digit(in_digit),
      .out_stb(out_stb), .p29_digit(p29_digit), .p43_digit(p43_digit)
   );

   // one cycle: compare outputs due now, then drive next input and record its expectation
   task automatic tick(input bit stb, input logic [DW-1:0] dig, input bit chk,
                       input logic [DW-1:0] e29, input logic [DW-1:0] e43, input string tag);
      exp_t e;
      @(negedge clk);
      if (exp_q.size() >= LAT) begin
         e = exp_q.pop_front();
         checks++;
         if (out_stb !== e.stb) begin
            errors++;
            $display("FAIL R3 out_stb actual=%0b expected=%0b", out_stb, e.stb);
         end
         if (e.chk) begin
            checks++;
            if (p29_digit !== e.e29) begin
               errors++;
               $display("FAIL R1 (%s) p29 digit actual=%0h expected=%0h", e.tag, p29_digit, e.e29);
            end
            checks++;
            if (p43_digit !== e.e43) begin
               errors++;
               $display("FAIL R2 (%s) p43 digit actual=%0h expected=%0h", e.tag, p43_digit, e.e43);
            end
         end
      end
      in_stb   = stb;
      in_digit = dig;
      e.chk = chk; e.stb = stb; e.e29 = e29; e.e43 = e43; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // full word; tail digits carry garbage that must be ignored (R4)
   task automatic send_word(input int x, input string tag);
      longint p29 = 64'(29) * longint'(x);
      longint p43 = 64'(43) * longint'(x);
      for (int j = 0; j < ND_OUT; j++) begin
         logic [DW-1:0] d;
         d = (j < ND_IN) ? DW'(x >>> (j*DW)) : DW'($urandom);
         tick(j == 0, d, 1'b1, DW'(p29 >>> (j*DW)), DW'(p43 >>> (j*DW)), tag);
      end
   endtask

   // word abandoned after k digits (R6): its outputs are not checked
   task automatic send_partial(input int x, input int k);
      for (int j = 0; j < k; j++) begin
         tick(j == 0, DW'(x >>> (j*DW)), 1'b0, '0, '0, "R6");
      end
   endtask

   task automatic idle(input int n);
      for (int j = 0; j < n; j++) tick(1'b0, DW'($urandom), 1'b0, '0, '0, "R9");
   endtask

   initial begin
      int lo = -(1 << (NW-1));
      int hi = (1 << (NW-1)) - 1;
      repeat (3) @(negedge clk);
      // R8: reset state
      checks++;
      if (out_stb !== 1'b0 || p29_digit !== '0 || p43_digit !== '0) begin
         errors++;
         $display("FAIL R8 reset outputs actual=%0b/%0h/%0h expected=0/0/0",
                  out_stb, p29_digit, p43_digit);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_stb !== 1'b0 || p29_digit !== '0 || p43_digit !== '0) begin
         errors++;
         $display("FAIL R8 after release actual=%0b/%0h/%0h expected=0/0/0",
                  out_stb, p29_digit, p43_digit);
      end
      // basic values
      send_word(0, "R1");
      send_word(1, "R1");
      send_word(-1, "R2");
      send_word(5, "R4");
      // R7: extremes
      send_word(lo, "R7");
      send_word(hi, "R7");
      send_word(lo, "R7");
      // R5: back-to-back random words
      for (int i = 0; i < 40; i++) send_word($urandom_range(hi - lo) + lo, "R5");
      // R9: gaps between words
      idle(5);
      send_word(-77, "R9");
      idle(1);
      send_word(93, "R9");
      idle(13);
      // R6: aborted words followed by a fresh word
      send_partial(hi, 2);
      send_word(-3, "R6");
      send_partial(lo, ND_OUT - 1);
      send_word(117, "R6");
      send_partial(-1, 1);
      send_word(lo, "R6");
      for (int i = 0; i < 20; i++) begin
         send_partial($urandom_range(hi - lo) + lo, 1 + (i % (ND_OUT - 1)));
         send_word($urandom_range(hi - lo) + lo, "R6");
      end
      idle(LAT + 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule